// File: doc/BRIEF.md
# Serial Frame Transmitter with Parity

This block turns one parallel byte into an asynchronous serial frame on a single line. A frame opens with a low start bit. The eight data bits follow, least significant bit first. An optional parity bit comes next, and a high stop bit closes the frame. Bit timing comes from an oversample tick. A divider sets the tick rate from the clock frequency, the baud rate and the oversampling factor, so the transmitter uses the same tick rate as a matching receiver. The transmitter moves to the next bit position after a fixed number of ticks.

A source offers a byte with a valid/ready handshake. When the handshake completes, the block captures the byte, the parity enable and the parity type, and sends the whole frame. It then accepts the next byte. A busy flag is high while a frame is in flight.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `txd` is high, `busy` is low and `in_ready` is high.
- R2: Every frame begins with one start bit at level 0 and ends with one stop bit at level 1.
- R3: The 8 data bits follow the start bit, bit 0 of `in_data` first and bit 7 last.
- R4: When `par_enable` was 1 at acceptance, one parity bit is sent between data bit 7 and the stop bit. Its value is the XOR of the 8 data bits when `par_odd` was 0 (even parity). When `par_odd` was 1 it is the inverse of that XOR (odd parity).
- R5: When `par_enable` was 0 at acceptance, the stop bit follows data bit 7 directly, giving a 10-bit frame.
- R6: The tick period is CLK_FREQ_HZ/(BAUD_RATE*OVERSAMPLE) clock cycles, rounded to the nearest integer (minimum 1). Every bit lasts exactly OVERSAMPLE tick periods. The start bit begins at the clock edge that accepts the byte.
- R7: A byte is accepted only at a rising edge where `in_valid` and `in_ready` are both high. While `in_valid` is low, no frame starts and the line stays high.
- R8: From the accepting edge, `in_ready` stays low, and `busy` stays high, for exactly the frame length times the bit time. This is 10 or 11 bit times.
- R9: The data byte, `par_enable` and `par_odd` are captured at acceptance. Changing them during a frame does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte |
| par_enable | input | 1 | Insert a parity bit in the frame |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | Frame in flight |

## Verification
A wrong sequencer state or a wrong bit index shows on `txd` as a wrong level inside a bit slot. The bench samples every bit at the first and last cycle of its slot, so such an error is caught within one bit time of its cause. A divider or oversample counter that is off by one moves a bit boundary. The next edge-of-slot sample catches this, and the length of the `in_ready` low window shows it again at the end of the frame. If the byte or the parity settings are not held through the frame, the data or parity slots after a mid-frame input change show the wrong value.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              par_en;
        logic              par_bit;
    } tx_job_t;

    // Clock cycles per oversample tick, rounded to nearest, at least 1.
    function automatic int unsigned tick_div(input longint unsigned clk_hz,
                                             input longint unsigned baud,
                                             input longint unsigned os);
        longint unsigned den;
        longint unsigned q;
        den = baud * os;
        q   = (clk_hz + den / 2) / den;
        return (q < 1) ? 1 : int'(q);
    endfunction

    function automatic logic frame_parity(input logic [BYTE_W-1:0] d,
                                          input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sft_tick_gen.sv
module sft_tick_gen #(
    parameter int unsigned DIV = 27
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R6
        end
    endgenerate

endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
    parameter int unsigned OS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (OS > 1) ? $clog2(OS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    logic [CW-1:0] os_cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            os_cnt <= '0;
        end else if (tick) begin
            os_cnt <= (os_cnt == LAST) ? '0 : os_cnt + 1'b1;
        end
    end

    assign bit_end = tick && (os_cnt == LAST);

    AST_OS_BOUND: assert property (@(posedge clk) disable iff (rst)
        os_cnt <= LAST); // R6
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (os_cnt == '0)); // R6

endmodule

// File: rtl/sft_frame_seq.sv
module sft_frame_seq
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_end,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              par_enable,
    input  logic              par_odd,
    output logic              txd,
    output logic              busy
);
    localparam int IW = $clog2(BYTE_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(BYTE_W - 1);

    tx_state_e     state;
    tx_job_t       job;
    logic [IW-1:0] idx;
    logic          txd_q;
    logic          accept;

    assign in_ready = (state == ST_IDLE);
    assign busy     = !in_ready;
    assign accept   = in_valid && in_ready;
    assign txd      = txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= '0;
            idx   <= '0;
            txd_q <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    txd_q <= 1'b1;
                    if (accept) begin
                        job.data    <= in_data;
                        job.par_en  <= par_enable;
                        job.par_bit <= frame_parity(in_data, par_odd);
                        idx         <= '0;
                        txd_q       <= 1'b0;
                        state       <= ST_START;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        txd_q <= job.data[0];
                        idx   <= '0;
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        if (idx == LAST_IDX) begin
                            if (job.par_en) begin
                                txd_q <= job.par_bit;
                                state <= ST_PAR;
                            end else begin
                                txd_q <= 1'b1;
                                state <= ST_STOP;
                            end
                        end else begin
                            txd_q <= job.data[idx + 1'b1];
                            idx   <= idx + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        txd_q <= 1'b1;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        txd_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    txd_q <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd); // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(txd)); // R2
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd); // R1
    AST_ACCEPT_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid && in_ready)); // R7
    AST_JOB_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(job)); // R9
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state inside {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP}); // R2

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned BAUD_RATE   = 115_200,
    parameter int unsigned OVERSAMPLE  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              par_enable,
    input  logic              par_odd,
    output logic              txd,
    output logic              busy
);
    localparam int unsigned DIV = tick_div(CLK_FREQ_HZ, BAUD_RATE, OVERSAMPLE);

    logic tick;
    logic bit_end;

    sft_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    sft_bit_timer #(.OS(OVERSAMPLE)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .tick    (tick),
        .bit_end (bit_end)
    );

    sft_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .bit_end    (bit_end),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .par_enable (par_enable),
        .par_odd    (par_odd),
        .txd        (txd),
        .busy       (busy)
    );

endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;

    localparam int unsigned CLK_HZ = 50_000_000;
    localparam int unsigned BAUD   = 660_000;
    localparam int unsigned OS     = 16;
    // R6: 50e6/(660000*16) = 4.73 -> rounds to 5 cycles per tick
    localparam int TICK_CYC = $rtoi(50.0e6 / (660000.0 * 16.0) + 0.5);
    localparam int BIT      = TICK_CYC * OS;
    localparam int LIMIT    = 100_000;

    typedef struct packed {
        logic [7:0] d;
        logic       pe;
        logic       po;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready;
    logic       par_enable;
    logic       par_odd;
    logic       txd;
    logic       busy;

    int total = 0;
    int bad   = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    serial_frame_tx #(
        .CLK_FREQ_HZ (CLK_HZ),
        .BAUD_RATE   (BAUD),
        .OVERSAMPLE  (OS)
    ) u_serial_frame_tx (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .par_enable (par_enable),
        .par_odd    (par_odd),
        .txd        (txd),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops the expected frame and checks each bit at the first
    // and last cycle of its slot.
    task automatic frame_check();
        exp_t e;
        logic b [0:10];
        int   n;
        string tag;
        if (q.size() == 0) begin
            chk(0, "R7 unexpected start bit", 0, 1);
            return;
        end
        e = q.pop_front();
        n = e.pe ? 11 : 10;
        b[0] = 1'b0;
        for (int i = 0; i < 8; i++) b[i+1] = e.d[i];
        b[9]  = e.pe ? ((^e.d) ^ e.po) : 1'b1;
        b[10] = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0 || k == n - 1)  tag = (k == 9) ? "R5 stop after data" : "R2 start/stop";
            else if (k <= 8)           tag = "R3 data bit";
            else                       tag = "R4 parity bit";
            chk(txd === b[k], tag, int'(txd), int'(b[k]));
            repeat (BIT - 1) @(negedge clk);
            chk(txd === b[k], "R6 bit end timing", int'(txd), int'(b[k]));
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst === 1'b0 && txd === 1'b0) frame_check();
        end
    end

    task automatic send(input logic [7:0] d, input logic pe, input logic po, input bit midchg);
        int cnt;
        in_data    = d;
        par_enable = pe;
        par_odd    = po;
        in_valid   = 1'b1;
        while (!in_ready) @(negedge clk);
        q.push_back('{d: d, pe: pe, po: po});
        @(negedge clk);
        cnt = 0;
        while (!in_ready) begin
            cnt++;
            if (midchg && cnt == 3 * BIT) begin
                in_data    = ~d;            // R9: must not affect this frame
                par_enable = ~pe;
                par_odd    = ~po;
            end
            if (cnt > 12 * BIT) break;
            @(negedge clk);
        end
        chk(cnt == (pe ? 11 : 10) * BIT, "R8 ready low window", cnt, (pe ? 11 : 10) * BIT);
    endtask

    task automatic idle_check(input int cycles, input string tag);
        bit ok = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b1) ok = 1'b0;
        end
        chk(ok, tag, int'(ok), 1);
    endtask

    initial begin
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_data    = '0;
        par_enable = 1'b0;
        par_odd    = 1'b0;
        fork
            begin
                repeat (4) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
                chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
                chk(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
                idle_check(60, "R7 valid low keeps line idle");

                send(8'h55, 1'b0, 1'b0, 1'b0);   // R5 no parity
                send(8'hA5, 1'b1, 1'b0, 1'b0);   // R4 even
                send(8'hA5, 1'b1, 1'b1, 1'b0);   // R4 odd
                send(8'h00, 1'b1, 1'b0, 1'b0);
                send(8'h00, 1'b1, 1'b1, 1'b0);
                send(8'hFF, 1'b1, 1'b0, 1'b0);
                send(8'h80, 1'b0, 1'b0, 1'b0);   // R3 msb only
                send(8'h01, 1'b1, 1'b1, 1'b0);   // R3 lsb only
                send(8'h3C, 1'b1, 1'b0, 1'b1);   // R9 mid-frame change
                send(8'hC6, 1'b0, 1'b1, 1'b1);   // R9 parity enable flipped mid-frame

                idle_check(3 * BIT, "R1 idle after frames");
                chk(q.size() == 0, "R3 all frames observed", q.size(), 0);
            end
            begin
                repeat (LIMIT) @(posedge clk);
                chk(0, "R8 watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule